// File: doc/BRIEF.md
# Protected Page Translation Buffer

This block keeps eight recent virtual-to-physical page translations next to the processor's memory port. A lookup supplies a virtual address, a read/write flag and the current privilege level. One cycle later the block reports exactly one of three outcomes: a hit with the physical address, a miss, or a protection fault. Pages are 4 KiB, so the low 12 address bits pass straight through. The upper bits are the virtual page number, which is compared against every stored entry in parallel.

Every entry has a valid flag, a physical page number, three permission flags (readable, writable, supervisor-only), a recently-used flag and a modified flag. An allowed lookup that hits marks its entry as recently used, and a write hit also marks it as modified. A fill port installs a new translation. It chooses a slot by preferring empty slots, then slots not recently used, and finally a rotating pointer. It reports which slot it chose and what was evicted, including whether the evicted page was modified and must be written back. A sweep input clears every recently-used flag at once. Walking the page table and handling faults are left to the surrounding logic.

Top module: `xlat_cache`

## Requirements
- R1: On a hit, `res_paddr` equals the entry's physical page number concatenated with `lk_vaddr[11:0]`. The virtual page number is `lk_vaddr[31:12]`.
- R2: A lookup presented in cycle t produces exactly one of `res_hit`, `res_miss`, `res_fault` high in cycle t+1. In a cycle after no lookup, all three are low.
- R3: A lookup whose page number matches no valid entry reports a miss. Reset invalidates every entry and drives all outputs low.
- R4: A read of a page without read permission, or a write of a page without write permission, reports a fault. On any non-hit result `res_paddr` is zero.
- R5: A page marked supervisor-only faults when `lk_super` is 0, and hits when `lk_super` is 1 and the read/write permission allows the access.
- R6: A hit sets the entry's recently-used flag. A faulting access changes no status flag.
- R7: A write hit sets the entry's modified flag, and read hits leave it unchanged. On eviction the flag appears on `ev_dirty`.
- R8: The fill victim is the lowest-numbered invalid slot. If every slot is valid, it is the lowest-numbered slot whose recently-used flag is clear.
- R9: When every slot is valid and recently used, the victim is a rotating pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, each time it is used.
- R10: `ref_clear` clears every recently-used flag. A hit in the same cycle keeps its own entry's flag set.
- R11: A fill installs a valid entry with both status flags clear. In the next cycle `fill_done` pulses with `fill_slot`, and `ev_valid`, `ev_vpn` and `ev_dirty` describe the replaced entry. A lookup in the same cycle as a fill sees the contents from before the fill.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_super | input | 1 | 1 = supervisor privilege |
| res_hit | output | 1 | Translation succeeded |
| res_miss | output | 1 | No matching entry |
| res_fault | output | 1 | Permission violation |
| res_paddr | output | 32 | Physical address on hit, else zero |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | 20 | Virtual page number to install |
| fill_ppn | input | 20 | Physical page number to install |
| fill_rd | input | 1 | Read permission |
| fill_wr | input | 1 | Write permission |
| fill_prot | input | 1 | Supervisor-only page |
| ref_clear | input | 1 | Clear all recently-used flags |
| fill_done | output | 1 | Fill completed last cycle |
| fill_slot | output | 3 | Slot written by that fill |
| ev_valid | output | 1 | A valid entry was replaced |
| ev_vpn | output | 20 | Page number of the replaced entry |
| ev_dirty | output | 1 | Replaced entry was modified |

## Verification
Two pairs of functions can meet in one cycle. In the first, a sweep is raised in the same cycle as a hit. The bench then fills twice, and the chosen slots show that only the hit entry kept its flag. In the second, a lookup and a fill for the same page are issued together. The expected result is a miss, and the following lookup must hit. The scoreboard queues an expected outcome for every lookup and every fill and compares each one in the cycle it appears.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
   typedef struct packed {
      logic prot;
      logic rd;
      logic wr;
   } xperm_t;

   function automatic logic perm_denied(xperm_t p, logic is_wr, logic is_sup);
      return (p.prot && !is_sup) || (is_wr ? !p.wr : !p.rd);
   endfunction
endpackage

// File: rtl/xlat_match.sv
module xlat_match #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int SLOT_W  = 3
) (
   input  logic [ENTRIES-1:0]       valid_i,
   input  logic [ENTRIES*VPN_W-1:0] tags_i,
   input  logic [VPN_W-1:0]         key_i,
   output logic [ENTRIES-1:0]       match_o,
   output logic                     any_o,
   output logic [SLOT_W-1:0]        idx_o
);
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_o[g] = valid_i[g] && (tags_i[g*VPN_W +: VPN_W] == key_i);
   end

   assign any_o = |match_o;

   always_comb begin
      idx_o = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match_o[i]) idx_o = SLOT_W'(i);
      end
   end
endmodule

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int ENTRIES         = 8,
   parameter int SLOT_W          = 3,
   parameter bit FALLBACK_ROTATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ENTRIES-1:0] valid_i,
   input  logic [ENTRIES-1:0] ref_i,
   input  logic               take_i,
   output logic [SLOT_W-1:0]  victim_o
);
   logic [SLOT_W-1:0] ptr;
   logic              all_used;
   logic              got_free, got_cold;
   logic [SLOT_W-1:0] free_idx, cold_idx;

   assign all_used = (&valid_i) && (&ref_i);

   always_comb begin
      got_free = 1'b0;
      free_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!got_free && !valid_i[i]) begin
            got_free = 1'b1;
            free_idx = SLOT_W'(i);
         end
      end
      got_cold = 1'b0;
      cold_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!got_cold && !ref_i[i]) begin
            got_cold = 1'b1;
            cold_idx = SLOT_W'(i);
         end
      end
   end

   generate
      if (FALLBACK_ROTATE) begin : g_rot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                ptr <= '0;
            else if (take_i && all_used)
               ptr <= (ptr == SLOT_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
         end
      end else begin : g_fixed
         assign ptr = '0;
      end
   endgenerate

   assign victim_o = got_free ? free_idx : (got_cold ? cold_idx : ptr);

   AST_VICTIM_FREE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      !(&valid_i) |-> !valid_i[victim_o]);                       // R8
   AST_VICTIM_COLD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      ((&valid_i) && !(&ref_i)) |-> !ref_i[victim_o]);            // R8
   AST_ROTATE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (take_i && all_used && victim_o != SLOT_W'(ENTRIES - 1) && FALLBACK_ROTATE)
      |=> (ptr == $past(victim_o) + 1'b1));                       // R9
endmodule

// File: rtl/xlat_cache.sv
module xlat_cache #(
   parameter int VA_W      = 32,
   parameter int PA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int ENTRIES   = 8,
   parameter bit FALLBACK_ROTATE = 1'b1,
   localparam int VPN_W  = VA_W - PAGE_BITS,
   localparam int PPN_W  = PA_W - PAGE_BITS,
   localparam int SLOT_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lk_valid,
   input  logic [VA_W-1:0]   lk_vaddr,
   input  logic              lk_write,
   input  logic              lk_super,
   output logic              res_hit,
   output logic              res_miss,
   output logic              res_fault,
   output logic [PA_W-1:0]   res_paddr,
   input  logic              fill_valid,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic              fill_rd,
   input  logic              fill_wr,
   input  logic              fill_prot,
   input  logic              ref_clear,
   output logic              fill_done,
   output logic [SLOT_W-1:0] fill_slot,
   output logic              ev_valid,
   output logic [VPN_W-1:0]  ev_vpn,
   output logic              ev_dirty
);
   import xlat_pkg::*;

   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W || PAGE_BITS >= PA_W) begin : g_bad_page
      $error("xlat_cache: PAGE_BITS out of range");
   end
   if (ENTRIES < 2) begin : g_bad_depth
      $error("xlat_cache: need at least two entries");
   end

   logic [ENTRIES-1:0]       val_vec, ref_vec, dirty_vec;
   logic [ENTRIES*VPN_W-1:0] vpn_flat;
   logic [PPN_W-1:0]         ppn_arr  [ENTRIES];
   xperm_t                   perm_arr [ENTRIES];

   logic [VPN_W-1:0]  lk_vpn;
   logic [ENTRIES-1:0] match_vec;
   logic              match_any;
   logic [SLOT_W-1:0] hit_idx;
   logic [SLOT_W-1:0] vic_idx;
   logic              denied;
   logic              hit_now, miss_now, fault_now;
   xperm_t            fill_perm;

   assign lk_vpn    = lk_vaddr[VA_W-1:PAGE_BITS];
   assign fill_perm = '{prot: fill_prot, rd: fill_rd, wr: fill_wr};

   xlat_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .SLOT_W(SLOT_W)) u_match (
      .valid_i (val_vec),
      .tags_i  (vpn_flat),
      .key_i   (lk_vpn),
      .match_o (match_vec),
      .any_o   (match_any),
      .idx_o   (hit_idx)
   );

   xlat_victim #(.ENTRIES(ENTRIES), .SLOT_W(SLOT_W),
                 .FALLBACK_ROTATE(FALLBACK_ROTATE)) u_victim (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (val_vec),
      .ref_i    (ref_vec),
      .take_i   (fill_valid),
      .victim_o (vic_idx)
   );

   assign denied    = perm_denied(perm_arr[hit_idx], lk_write, lk_super);
   assign hit_now   = lk_valid && match_any && !denied;
   assign fault_now = lk_valid && match_any && denied;
   assign miss_now  = lk_valid && !match_any;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      logic             e_val, e_ref, e_dirty;
      logic [VPN_W-1:0] e_vpn;
      logic [PPN_W-1:0] e_ppn;
      xperm_t           e_perm;
      logic             replace, touched;

      assign replace = fill_valid && (vic_idx == SLOT_W'(g));
      assign touched = hit_now && (hit_idx == SLOT_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            e_val   <= 1'b0;
            e_ref   <= 1'b0;
            e_dirty <= 1'b0;
            e_vpn   <= '0;
            e_ppn   <= '0;
            e_perm  <= '0;
         end else if (replace) begin
            e_val   <= 1'b1;
            e_ref   <= 1'b0;
            e_dirty <= 1'b0;
            e_vpn   <= fill_vpn;
            e_ppn   <= fill_ppn;
            e_perm  <= fill_perm;
         end else if (touched) begin
            e_ref <= 1'b1;
            if (lk_write) e_dirty <= 1'b1;
         end else if (ref_clear) begin
            e_ref <= 1'b0;
         end
      end

      assign val_vec[g]                 = e_val;
      assign ref_vec[g]                 = e_ref;
      assign dirty_vec[g]               = e_dirty;
      assign vpn_flat[g*VPN_W +: VPN_W] = e_vpn;
      assign ppn_arr[g]                 = e_ppn;
      assign perm_arr[g]                = e_perm;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_hit   <= 1'b0;
         res_miss  <= 1'b0;
         res_fault <= 1'b0;
         res_paddr <= '0;
      end else begin
         res_hit   <= hit_now;
         res_miss  <= miss_now;
         res_fault <= fault_now;
         res_paddr <= hit_now ? {ppn_arr[hit_idx], lk_vaddr[PAGE_BITS-1:0]} : '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_done <= 1'b0;
         fill_slot <= '0;
         ev_valid  <= 1'b0;
         ev_vpn    <= '0;
         ev_dirty  <= 1'b0;
      end else begin
         fill_done <= fill_valid;
         fill_slot <= fill_valid ? vic_idx : '0;
         ev_valid  <= fill_valid && val_vec[vic_idx];
         ev_vpn    <= (fill_valid && val_vec[vic_idx]) ? vpn_flat[vic_idx*VPN_W +: VPN_W] : '0;
         ev_dirty  <= fill_valid && val_vec[vic_idx] && dirty_vec[vic_idx];
      end
   end

   AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({res_hit, res_miss, res_fault}));                     // R2
   AST_ANSWER_EACH: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (res_hit || res_miss || res_fault));               // R2
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !(res_hit || res_miss || res_fault));             // R2
   AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> (!res_hit ||
         res_paddr[PAGE_BITS-1:0] == $past(lk_vaddr[PAGE_BITS-1:0]))); // R1
   AST_NONHIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !res_hit |-> (res_paddr == '0));                                // R4
   AST_HIT_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_now && !(fill_valid && vic_idx == hit_idx))
      |=> ref_vec[$past(hit_idx)]);                                   // R6
   AST_WRITE_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_now && lk_write && !(fill_valid && vic_idx == hit_idx))
      |=> dirty_vec[$past(hit_idx)]);                                 // R7
   AST_SWEEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ref_clear && !lk_valid) |=> (ref_vec == '0));                  // R10
   AST_FILL_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      fill_valid |=> fill_done);                                      // R11
endmodule

// File: tb/xlat_cache_test.sv
module xlat_cache_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lk_valid = 1'b0;
   logic [31:0] lk_vaddr = '0;
   logic        lk_write = 1'b0;
   logic        lk_super = 1'b0;
   logic        res_hit, res_miss, res_fault;
   logic [31:0] res_paddr;
   logic        fill_valid = 1'b0;
   logic [19:0] fill_vpn = '0;
   logic [19:0] fill_ppn = '0;
   logic        fill_rd = 1'b0, fill_wr = 1'b0, fill_prot = 1'b0;
   logic        ref_clear = 1'b0;
   logic        fill_done;
   logic [2:0]  fill_slot;
   logic        ev_valid;
   logic [19:0] ev_vpn;
   logic        ev_dirty;

   always #5 clk = ~clk;

   xlat_cache uut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_super(lk_super),
      .res_hit(res_hit), .res_miss(res_miss), .res_fault(res_fault), .res_paddr(res_paddr),
      .fill_valid(fill_valid), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
      .fill_rd(fill_rd), .fill_wr(fill_wr), .fill_prot(fill_prot),
      .ref_clear(ref_clear),
      .fill_done(fill_done), .fill_slot(fill_slot),
      .ev_valid(ev_valid), .ev_vpn(ev_vpn), .ev_dirty(ev_dirty)
   );

   localparam int K_HIT = 0, K_MISS = 1, K_FAULT = 2;

   typedef struct {
      int          kind;
      logic [31:0] pa;
      string       tag;
   } lk_exp_t;

   typedef struct {
      int          slot;
      bit          ev;
      logic [19:0] evpn;
      bit          ed;
      string       tag;
   } fl_exp_t;

   lk_exp_t lkq[$];
   fl_exp_t flq[$];
   int checks = 0;
   int errors = 0;
   bit finished = 1'b0;

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic put_lookup(logic [19:0] vpn, logic [11:0] off, bit wr, bit sup,
                             int kind, logic [19:0] ppn, string tag);
      lk_exp_t e;
      lk_valid = 1'b1;
      lk_vaddr = {vpn, off};
      lk_write = wr;
      lk_super = sup;
      e.kind = kind;
      e.pa   = (kind == K_HIT) ? {ppn, off} : 32'h0;
      e.tag  = tag;
      lkq.push_back(e);
   endtask

   task automatic put_fill(logic [19:0] vpn, logic [19:0] ppn, bit rd, bit wr, bit prot,
                           int slot, bit ev, logic [19:0] evpn, bit ed, string tag);
      fl_exp_t e;
      fill_valid = 1'b1;
      fill_vpn   = vpn;
      fill_ppn   = ppn;
      fill_rd    = rd;
      fill_wr    = wr;
      fill_prot  = prot;
      e.slot = slot; e.ev = ev; e.evpn = evpn; e.ed = ed; e.tag = tag;
      flq.push_back(e);
   endtask

   task automatic step();
      @(negedge clk);
      lk_valid   = 1'b0;
      fill_valid = 1'b0;
      ref_clear  = 1'b0;
   endtask

   // monitor: compare each registered result one edge after its request
   bit lk_s, fl_s;
   always @(posedge clk) begin
      lk_s = lk_valid;
      fl_s = fill_valid;
      #1;
      if (rst_n) begin
         if (lk_s) begin
            if (lkq.size() == 0) chk(1'b0, "R2", "unexpected lookup", 0, 0);
            else begin
               lk_exp_t e;
               int act;
               e = lkq.pop_front();
               act = res_hit ? K_HIT : res_miss ? K_MISS : res_fault ? K_FAULT : 9;
               chk(act == e.kind && $countones({res_hit, res_miss, res_fault}) == 1,
                   e.tag, "outcome", act, e.kind);
               chk(res_paddr == e.pa, e.tag, "paddr", res_paddr, e.pa);
            end
         end else begin
            chk(!(res_hit || res_miss || res_fault), "R2", "idle outcome",
                {res_hit, res_miss, res_fault}, 0);
         end
         if (fl_s) begin
            if (flq.size() == 0) chk(1'b0, "R11", "unexpected fill", 0, 0);
            else begin
               fl_exp_t f;
               f = flq.pop_front();
               chk(fill_done == 1'b1, f.tag, "fill_done", fill_done, 1);
               chk(int'(fill_slot) == f.slot, f.tag, "fill_slot", fill_slot, f.slot);
               chk(ev_valid == f.ev, f.tag, "ev_valid", ev_valid, f.ev);
               if (f.ev) begin
                  chk(ev_vpn == f.evpn, f.tag, "ev_vpn", ev_vpn, f.evpn);
                  chk(ev_dirty == f.ed, f.tag, "ev_dirty", ev_dirty, f.ed);
               end
            end
         end else begin
            chk(!fill_done, "R11", "idle fill_done", fill_done, 0);
         end
      end
   end

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=expired expected=finished");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(!(res_hit || res_miss || res_fault) && res_paddr == 0 && !fill_done, "R3",
          "reset outputs", {res_hit, res_miss, res_fault}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      put_lookup(20'h00100, 12'h123, 0, 0, K_MISS, 0, "R3 empty after reset"); step();

      // fill eight slots: empty slots taken lowest first
      for (int i = 0; i < 8; i++) begin
         put_fill(20'h00100 + 20'(i), 20'h00500 + 20'(i), 1, (i != 1), (i == 2),
                  i, 0, 0, 0, "R8 free slot order");
         step();
      end

      put_lookup(20'h00100, 12'hABC, 0, 0, K_HIT, 20'h00500, "R1 read hit"); step();
      put_lookup(20'h00100, 12'h004, 1, 0, K_HIT, 20'h00500, "R7 write hit"); step();
      put_lookup(20'h00101, 12'h010, 1, 0, K_FAULT, 0, "R4 write to read-only"); step();
      put_lookup(20'h00102, 12'h020, 0, 0, K_FAULT, 0, "R5 user on protected"); step();
      put_lookup(20'h00102, 12'h7FF, 0, 1, K_HIT, 20'h00502, "R5 supervisor on protected"); step();
      put_lookup(20'h001FF, 12'h000, 0, 0, K_MISS, 0, "R3 absent page"); step();

      // slot 1 stayed cold because its only access faulted
      put_fill(20'h00108, 20'h00508, 1, 1, 0, 1, 1, 20'h00101, 0, "R6 fault leaves flag clear");
      step();

      put_lookup(20'h00108, 12'h111, 0, 0, K_HIT, 20'h00508, "R11 new entry hits"); step();
      for (int i = 3; i < 8; i++) begin
         put_lookup(20'h00100 + 20'(i), 12'(i), 0, 0, K_HIT, 20'h00500 + 20'(i), "R6 warm up");
         step();
      end

      // all slots recently used: rotating pointer at slot 0, which was written
      put_fill(20'h00109, 20'h00509, 1, 1, 0, 0, 1, 20'h00100, 1, "R9 pointer slot 0 / R7 dirty evict");
      step();
      put_lookup(20'h00109, 12'hFFF, 0, 0, K_HIT, 20'h00509, "R1 refilled slot"); step();
      put_fill(20'h0010A, 20'h0050A, 1, 1, 0, 1, 1, 20'h00108, 0, "R9 pointer advanced / R7 read-only clean");
      step();
      put_lookup(20'h0010A, 12'h0A0, 0, 0, K_HIT, 20'h0050A, "R6 rewarm"); step();

      // sweep and hit in the same cycle
      ref_clear = 1'b1;
      put_lookup(20'h00109, 12'h001, 0, 0, K_HIT, 20'h00509, "R10 hit during sweep"); step();
      put_fill(20'h0010B, 20'h0050B, 1, 1, 0, 1, 1, 20'h0010A, 0, "R10 swept slot chosen, hit slot kept");
      step();
      put_lookup(20'h0010B, 12'h002, 0, 0, K_HIT, 20'h0050B, "R6 mark slot 1"); step();
      put_fill(20'h0010C, 20'h0050C, 1, 1, 0, 2, 1, 20'h00102, 0, "R10 slot 2 was swept");
      step();

      // lookup and fill of the same page in one cycle
      put_lookup(20'h0010D, 12'h333, 0, 0, K_MISS, 0, "R11 lookup sees old contents");
      put_fill(20'h0010D, 20'h0050D, 1, 1, 0, 2, 1, 20'h0010C, 0, "R11 cold new entry replaced");
      step();
      put_lookup(20'h0010D, 12'h333, 0, 0, K_HIT, 20'h0050D, "R11 visible next cycle"); step();

      repeat (3) @(negedge clk);
      chk(lkq.size() == 0 && flq.size() == 0, "R2", "pending expectations", lkq.size(), 0);
      report();
   end
endmodule